// File: doc/BRIEF.md
# Block DMA Controller

A register-programmed engine that copies one fixed-size block from a small internal block store into system memory on its own. Software programs a block number and a destination byte address through a four-register slave port, then writes the start code to the command register. The controller then streams every word of the block out of a bus-master write port, one valid/ready handshake per word. It finishes by raising a level interrupt that stays up until software clears it.

The internal store holds `NUM_BLOCKS` blocks of `BLOCK_BYTES` bytes each. Word `k` of block `b` is computed, not stored: `((b << 16) | k) ^ 0xA5A5_0000` for the default 32-bit word. A block number outside the store ends the command at once in an error state, and no memory write is made.

The control state machine has four states: IDLE (status 0), BUSY (status 1), DONE (status 2) and FAULT (status 3). Its transitions are:
- IDLE to BUSY on a start command with a valid block number.
- IDLE to FAULT on a start command with an out-of-range block number.
- BUSY to DONE on the handshake of the last word.
- DONE or FAULT to IDLE on a status clear write.

Top module: `bdma_top`

## Requirements
- R1: `s_reg` selects a register by index: 0 is the block number, 1 is the destination byte address, 2 is the command and 3 is the status. The block number and the address read back as written. The command register reads 0. The status register holds the state code in bits [1:0] and zeros in the upper bits.
- R2: Writing the value 1 to the command register in IDLE starts a command. The status reads 1 (busy) from the cycle after the write. Any other command value is ignored and leaves the status at 0 with no memory write.
- R3: A transfer issues exactly `BLOCK_BYTES/4` = 128 word writes. Word `k` goes to address `base + 4*k` and carries `((block << 16) | k) ^ 0xA5A5_0000`.
- R4: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_wdata` hold steady. A word counts as written only on a cycle with both high.
- R5: The cycle after the last word's handshake, the status reads 2 (done) and `irq` is 1. `irq` and `m_valid` are never high together.
- R6: A start command with a block number of `NUM_BLOCKS` or more gives status 3 (error) and `irq` = 1 from the next cycle. No memory write is made.
- R7: `irq` stays high in DONE and FAULT until a status write with bit 0 = 1. That write returns the status to 0 and drops `irq`. Reading the status has no side effect.
- R8: While busy, command writes and status clear writes are ignored. This includes a clear write in the same cycle as the last handshake. Writes to the block number or the address during a transfer do not change the words or addresses it produces.
- R9: In DONE or FAULT, a command write is ignored until the status has been cleared.
- R10: After reset, the status is 0, `irq` is 0, `m_valid` is 0, and the block number and address registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_sel | input | 1 | Slave access strobe |
| s_wr | input | 1 | Slave write enable (with s_sel) |
| s_reg | input | 2 | Register index |
| s_wdata | input | DATA_W | Slave write data |
| s_rdata | output | DATA_W | Slave read data for the register selected by s_reg (combinational) |
| m_valid | output | 1 | Master write request |
| m_ready | input | 1 | Memory accepts the current write |
| m_addr | output | DATA_W | Master write byte address |
| m_wdata | output | DATA_W | Master write data |
| irq | output | 1 | Level completion/error interrupt |

## Verification
Two things can meet in one cycle: a software status clear write and the final memory handshake that ends a transfer. The bench times a clear write so that its edge is exactly the edge of the last handshake, with memory always ready. The write must be ignored because the engine is still busy. The next cycle must then show status 2 with `irq` high, and all 128 words must have been accepted. Command writes that arrive during a transfer or while the done state is pending are judged the same way: by the status value and by the absence of further memory beats.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } bdma_state_e;

    localparam logic [1:0] REG_BLOCK  = 2'd0;
    localparam logic [1:0] REG_MADDR  = 2'd1;
    localparam logic [1:0] REG_CMD    = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;

    localparam int CMD_START = 1;

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_wr,
    input  logic [1:0]        s_reg,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    input  bdma_state_e       state,
    output logic [DATA_W-1:0] blk_reg,
    output logic [DATA_W-1:0] maddr_reg,
    output logic              start_req,
    output logic              clear_req
);

    logic wr_en;

    assign wr_en = s_sel && s_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_reg   <= '0;
            maddr_reg <= '0;
        end else if (wr_en) begin
            if (s_reg == REG_BLOCK) begin
                blk_reg <= s_wdata;
            end
            if (s_reg == REG_MADDR) begin
                maddr_reg <= s_wdata;
            end
        end
    end

    assign start_req = wr_en && (s_reg == REG_CMD) && (s_wdata == DATA_W'(CMD_START));
    assign clear_req = wr_en && (s_reg == REG_STATUS) && s_wdata[0];

    always_comb begin
        unique case (s_reg)
            REG_BLOCK:  s_rdata = blk_reg;
            REG_MADDR:  s_rdata = maddr_reg;
            REG_CMD:    s_rdata = '0;
            REG_STATUS: s_rdata = {{(DATA_W-2){1'b0}}, state};
            default:    s_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bdma_store.sv
module bdma_store #(
    parameter int              DATA_W     = 32,
    parameter int              NUM_BLOCKS = 4,
    parameter int              WORDS      = 128,
    parameter logic [DATA_W-1:0] SEED     = 32'hA5A5_0000,
    localparam int             IDX_W      = $clog2(WORDS)
) (
    input  logic [DATA_W-1:0] chk_blk,
    output logic              chk_ok,
    input  logic [DATA_W-1:0] rd_blk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    localparam int HALF = DATA_W / 2;

    assign chk_ok  = chk_blk < DATA_W'(NUM_BLOCKS);
    assign rd_word = ((rd_blk << HALF) | DATA_W'(rd_idx)) ^ SEED;

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
    import bdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 128,
    localparam int IDX_W    = $clog2(WORDS),
    localparam int WB_SHIFT = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              clear_req,
    input  logic              blk_ok,
    input  logic [DATA_W-1:0] blk_in,
    input  logic [DATA_W-1:0] maddr_in,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_addr,
    output logic [DATA_W-1:0] cur_blk,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              irq,
    output bdma_state_e       state
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    bdma_state_e       state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] blk_q, blk_d;
    logic [DATA_W-1:0] base_q, base_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            blk_q  <= '0;
            base_q <= '0;
        end else begin
            state  <= state_d;
            idx_q  <= idx_d;
            blk_q  <= blk_d;
            base_q <= base_d;
        end
    end

    always_comb begin
        state_d = state;
        idx_d   = idx_q;
        blk_d   = blk_q;
        base_d  = base_q;
        unique case (state)
            ST_IDLE: begin
                if (start_req) begin
                    blk_d   = blk_in;
                    base_d  = maddr_in;
                    idx_d   = '0;
                    state_d = blk_ok ? ST_BUSY : ST_FAULT;
                end
            end
            ST_BUSY: begin
                if (m_ready) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_DONE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (clear_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        m_valid = (state == ST_BUSY);
        irq     = (state == ST_DONE) || (state == ST_FAULT);
        m_addr  = base_q + (DATA_W'(idx_q) << WB_SHIFT);
        cur_blk = blk_q;
        cur_idx = idx_q;
    end

endmodule

// File: rtl/bdma_top.sv
module bdma_top
    import bdma_pkg::*;
#(
    parameter int                DATA_W      = 32,
    parameter int                NUM_BLOCKS  = 4,
    parameter int                BLOCK_BYTES = 512,
    parameter logic [DATA_W-1:0] SEED        = 32'hA5A5_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_wr,
    input  logic [1:0]        s_reg,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              irq
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = BLOCK_BYTES / WORD_BYTES;
    localparam int IDX_W      = $clog2(WORDS);

    bdma_state_e       state;
    logic [DATA_W-1:0] blk_reg, maddr_reg, cur_blk;
    logic [IDX_W-1:0]  cur_idx;
    logic              start_req, clear_req, blk_ok;

    bdma_regs #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sel     (s_sel),
        .s_wr      (s_wr),
        .s_reg     (s_reg),
        .s_wdata   (s_wdata),
        .s_rdata   (s_rdata),
        .state     (state),
        .blk_reg   (blk_reg),
        .maddr_reg (maddr_reg),
        .start_req (start_req),
        .clear_req (clear_req)
    );

    bdma_store #(
        .DATA_W     (DATA_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .WORDS      (WORDS),
        .SEED       (SEED)
    ) store_i (
        .chk_blk (blk_reg),
        .chk_ok  (blk_ok),
        .rd_blk  (cur_blk),
        .rd_idx  (cur_idx),
        .rd_word (m_wdata)
    );

    bdma_engine #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .clear_req (clear_req),
        .blk_ok    (blk_ok),
        .blk_in    (blk_reg),
        .maddr_in  (maddr_reg),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_addr    (m_addr),
        .cur_blk   (cur_blk),
        .cur_idx   (cur_idx),
        .irq       (irq),
        .state     (state)
    );

endmodule

// File: rtl/bdma_checker.sv
module bdma_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_sel,
    input logic              s_wr,
    input logic [1:0]        s_reg,
    input logic [DATA_W-1:0] s_wdata,
    input logic [DATA_W-1:0] s_rdata,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              irq
);

    localparam int WB = DATA_W / 8;

    logic clr_wr;
    assign clr_wr = s_sel && s_wr && (s_reg == 2'd3) && s_wdata[0];

    assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wdata)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> (!m_valid || (m_addr == $past(m_addr) + DATA_W'(WB))));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_no_beat_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && m_valid));

    assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |=> (m_valid || irq));

    assert_status_view_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_reg == 2'd3) |-> (((s_rdata[1:0] == 2'd1) == m_valid) && (s_rdata[1] == irq)));

endmodule

bind bdma_top bdma_checker #(.DATA_W(DATA_W)) checker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_sel   (s_sel),
    .s_wr    (s_wr),
    .s_reg   (s_reg),
    .s_wdata (s_wdata),
    .s_rdata (s_rdata),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .irq     (irq)
);

// File: tb/bdma_top_tb_top.sv
`timescale 1ns/1ps
module bdma_top_tb_top;

    localparam int WORDS = 128;
    localparam logic [31:0] SEED = 32'hA5A5_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_sel = 1'b0;
    logic        s_wr = 1'b0;
    logic [1:0]  s_reg = 2'd0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int beats    = 0;
    int rdy_mode = 0;
    int cyc_n    = 0;
    int wd       = 0;
    logic [31:0] exp_blk  = '0;
    logic [31:0] exp_base = '0;

    always #5 clk = ~clk;

    bdma_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_sel   (s_sel),
        .s_wr    (s_wr),
        .s_reg   (s_reg),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .irq     (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] b, input int k);
        return ((b << 16) | 32'(k)) ^ SEED;
    endfunction

    // memory model: ready pattern and per-beat checks (R3, R4)
    always @(negedge clk) begin
        bit rdy;
        cyc_n++;
        case (rdy_mode)
            1:       rdy = cyc_n[0];
            2:       rdy = (cyc_n % 3) == 0;
            default: rdy = 1'b1;
        endcase
        m_ready = rdy;
        if (m_valid && rdy && rst_n) begin
            check(m_addr == exp_base + 32'(beats * 4), "R3", "beat address", m_addr,
                  exp_base + 32'(beats * 4));
            check(m_wdata == exp_word(exp_blk, beats), "R3", "beat data", m_wdata,
                  exp_word(exp_blk, beats));
            beats++;
        end
    end

    task automatic bus_write(input logic [1:0] r, input logic [31:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b1; s_reg = r; s_wdata = d;
        @(negedge clk);
        s_sel = 1'b0; s_wr = 1'b0; s_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] r, output logic [31:0] d);
        s_reg = r;
        #1;
        d = s_rdata;
    endtask

    task automatic wait_irq();
        int t = 0;
        while (!irq && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_block(input logic [31:0] b, input logic [31:0] base, input int mode);
        logic [31:0] v;
        exp_blk = b; exp_base = base; rdy_mode = mode; beats = 0;
        bus_write(2'd0, b);
        bus_write(2'd1, base);
        bus_write(2'd2, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd1, "R2", "status busy after start", v, 32'd1);
        wait_irq();
        @(negedge clk);
        check(irq == 1'b1, "R5", "irq at completion", 32'(irq), 32'd1);
        check(beats == WORDS, "R3", "beat count", 32'(beats), 32'(WORDS));
        bus_read(2'd3, v);
        check(v == 32'd2, "R5", "status done", v, 32'd2);
        repeat (3) @(negedge clk);
        bus_read(2'd3, v);
        check(irq == 1'b1 && v == 32'd2, "R7", "irq and done held after status reads",
              {31'd0, irq}, 32'd1);
        bus_write(2'd3, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd0 && irq == 1'b0, "R7", "clear returns idle", v, 32'd0);
    endtask

    task automatic run_error(input logic [31:0] b);
        logic [31:0] v;
        beats = 0;
        bus_write(2'd0, b);
        bus_write(2'd2, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd3 && irq == 1'b1, "R6", "error status and irq", v, 32'd3);
        repeat (5) @(negedge clk);
        check(beats == 0 && m_valid == 1'b0, "R6", "no memory write on error", 32'(beats), 32'd0);
        bus_write(2'd3, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd0 && irq == 1'b0, "R7", "clear after error", v, 32'd0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        bus_read(2'd3, v);
        check(v == 32'd0, "R10", "status after reset", v, 32'd0);
        check(irq == 1'b0 && m_valid == 1'b0, "R10", "irq/valid after reset",
              {30'd0, irq, m_valid}, 32'd0);
        bus_read(2'd0, v);
        check(v == 32'd0, "R10", "block reg after reset", v, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 register readback
        bus_write(2'd0, 32'd3);
        bus_write(2'd1, 32'h1234_5678);
        bus_read(2'd0, v);
        check(v == 32'd3, "R1", "block readback", v, 32'd3);
        bus_read(2'd1, v);
        check(v == 32'h1234_5678, "R1", "address readback", v, 32'h1234_5678);
        bus_read(2'd2, v);
        check(v == 32'd0, "R1", "command reads zero", v, 32'd0);

        // R2 non-start command values ignored
        beats = 0;
        bus_write(2'd2, 32'd2);
        bus_write(2'd2, 32'h0000_0101);
        repeat (4) @(negedge clk);
        bus_read(2'd3, v);
        check(v == 32'd0 && beats == 0, "R2", "other command ignored", v, 32'd0);

        // R3/R4/R5 sweep over blocks and ready patterns
        for (int b = 0; b < 4; b++) begin
            for (int mode = 0; mode < 3; mode++) begin
                run_block(32'(b), 32'h0010_0000 + 32'(b) * 32'h1000 + 32'(mode) * 32'h100, mode);
            end
        end

        // R6 out-of-range blocks
        run_error(32'd4);
        run_error(32'h0001_0000);
        run_error(32'hFFFF_FFFF);

        // R8 writes during a transfer
        exp_blk = 32'd1; exp_base = 32'h0040_0000; rdy_mode = 1; beats = 0;
        bus_write(2'd0, 32'd1);
        bus_write(2'd1, 32'h0040_0000);
        bus_write(2'd2, 32'd1);
        repeat (10) @(negedge clk);
        bus_write(2'd2, 32'd1);
        bus_write(2'd3, 32'd1);
        bus_write(2'd0, 32'd2);
        bus_write(2'd1, 32'h0000_0000);
        bus_read(2'd3, v);
        check(v == 32'd1 && irq == 1'b0, "R8", "busy ignores command and clear", v, 32'd1);
        wait_irq();
        @(negedge clk);
        check(beats == WORDS, "R8", "transfer unaffected by register writes", 32'(beats), 32'(WORDS));

        // R9 command in done state ignored
        beats = 0;
        bus_write(2'd2, 32'd1);
        repeat (4) @(negedge clk);
        bus_read(2'd3, v);
        check(v == 32'd2 && beats == 0 && irq == 1'b1, "R9", "command ignored while done", v, 32'd2);
        bus_write(2'd3, 32'd1);

        // R8 clear write on the same edge as the last handshake
        exp_blk = 32'd2; exp_base = 32'h0080_0000; rdy_mode = 0; beats = 0;
        bus_write(2'd0, 32'd2);
        bus_write(2'd1, 32'h0080_0000);
        bus_write(2'd2, 32'd1);
        repeat (126) @(negedge clk);
        bus_write(2'd3, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd2 && irq == 1'b1, "R8", "clear coincident with last beat ignored", v, 32'd2);
        check(beats == WORDS, "R3", "beats before coincident clear", 32'(beats), 32'(WORDS));
        bus_write(2'd3, 32'd1);
        bus_read(2'd3, v);
        check(v == 32'd0 && irq == 1'b0, "R7", "later clear works", v, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule